// File: doc/BRIEF.md
# GPIO Pin Function and Output Register File

This block is the register file of a 54-pin general-purpose I/O controller. It sits on a simple 32-bit register bus with a byte address, a write enable, write data and combinational read data. Each pin carries a 3-bit function code. Ten codes are packed into each function word. The block exports every pin's code, so that pad muxing and the alternate peripherals outside the block can act on it.

A pin drives its output only while its code selects plain output. The output level is held in a per-pin latch. Software changes that latch only by writing a one-hot mask to a set word or a clear word. No read-modify-write of the latches is needed, so two agents can update different pins without interfering. A read-only level window returns the pin inputs after a two-flop synchronizer.

Top module: `gpio_func_regs`

## Requirements
- R1: After reset, every function field reads 0 (input), every output latch is 0, no output enable is asserted, and the level words read 0 while the pins are held low.
- R2: Pin p owns the 3-bit field at bits (p%10)*3 of the function word at byte offset (p/10)*4. A write to that word loads the field from the next clock edge on. The field is exported on pin_func[p*3+2:p*3] and reads back unchanged.
- R3: Bits 31:30 of every function word read 0. The fields of nonexistent pins 54 to 59 (word 0x14, bits 29:12) also read 0, whatever was written to them.
- R4: Function codes are: 0 input, 1 output, 4/5/6/7 alternates 0/1/2/3, 3 alternate 4, and 2 alternate 5. pin_oe[p] is high exactly when pin p's code is 1. No alternate code asserts it.
- R5: A write to the set words (0x1C for pins 0-31, 0x20 for pins 32-53, pin p at bit p%32) sets the latch of every pin whose bit is 1. Pins whose bit is 0 keep their latch value.
- R6: A write to the clear words (0x28 for pins 0-31, 0x2C for pins 32-53, same bit layout) clears the latch of every pin whose bit is 1. Pins whose bit is 0 keep their latch value.
- R7: pin_out always shows the latch. The latch keeps its value while the pin is an input or an alternate, so a pin switched to output drives the stored level from the same edge that loads code 1.
- R8: The level words (0x34 for pins 0-31, 0x38 for pins 32-53, pin p at bit p%32) show pin_in through two flops. A change shows after the second rising edge and not after the first. Bits 31:22 of 0x38 read 0.
- R9: Writes to the level words change neither the level readback nor any latch or function field. The set and clear words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte address; bits 1:0 ignored |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 54 | Raw pin input levels |
| pin_oe | output | 54 | Per-pin output enable |
| pin_out | output | 54 | Per-pin output value (latch) |
| pin_func | output | 162 | Per-pin 3-bit function code, pin p at [p*3+2:p*3] |

## Verification
Function fields, latches and the output enable all change on the rising edge that takes a write. The bench drives each write on a falling edge and reads the result at the next falling edge. The read path is combinational, so a read is sampled one step after the address is applied, away from any rising edge. The level window lags pin_in by two rising edges. The bench changes the pins on a falling edge, checks that one edge later the old value is still shown, and checks that after the second edge the new value appears.

// File: rtl/gpio_func_pkg.sv
package gpio_func_pkg;

  typedef enum logic [2:0] {
    FN_INPUT  = 3'd0,
    FN_OUTPUT = 3'd1,
    FN_ALT5   = 3'd2,
    FN_ALT4   = 3'd3,
    FN_ALT0   = 3'd4,
    FN_ALT1   = 3'd5,
    FN_ALT2   = 3'd6,
    FN_ALT3   = 3'd7
  } fn_code_e;

  localparam int OFS_FUNC  = 'h00;
  localparam int OFS_SET   = 'h1C;
  localparam int OFS_CLR   = 'h28;
  localparam int OFS_LEVEL = 'h34;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_ni = stage_q[1];
endmodule

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank #(
  parameter int NUM_PINS = 54,
  parameter int FIELD_W  = 3,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 6
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [DATA_W-1:0]           rd_data,
  output logic [NUM_PINS*FIELD_W-1:0] func_q
);
  localparam int PPR = DATA_W / FIELD_W;

  logic [NUM_PINS*FIELD_W-1:0] func_d;

  always_comb begin
    func_d = func_q;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (int'(wr_idx) == p / PPR)
        func_d[p*FIELD_W +: FIELD_W] = wr_data[(p % PPR)*FIELD_W +: FIELD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    func_q <= '0;
    else if (wr_en) func_q <= func_d;
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < PPR; s++) begin
      int pin;
      pin = int'(rd_idx) * PPR + s;
      if (pin < NUM_PINS)
        rd_data[s*FIELD_W +: FIELD_W] = func_q[pin*FIELD_W +: FIELD_W];
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    AST_FIELD_LOADS: assert property (@(posedge clk) disable iff (!rst_ni)
      (wr_en && int'(wr_idx) == g / PPR) |=>
        func_q[g*FIELD_W +: FIELD_W] == $past(wr_data[(g % PPR)*FIELD_W +: FIELD_W])); // R2
  end

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_en |=> $stable(func_q)); // R2
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int NUM_PINS = 54,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 6
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                set_en,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    bank_idx,
  input  logic [DATA_W-1:0]   mask,
  output logic [NUM_PINS-1:0] lat_q
);
  logic [NUM_PINS-1:0] lat_d;
  logic                upd_en;

  assign upd_en = set_en | clr_en;

  always_comb begin
    lat_d = lat_q;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (int'(bank_idx) == p / DATA_W && mask[p % DATA_W]) begin
        if (set_en)      lat_d[p] = 1'b1;
        else if (clr_en) lat_d[p] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     lat_q <= '0;
    else if (upd_en) lat_q <= lat_d;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_ni)
      (set_en && int'(bank_idx) == g / DATA_W && mask[g % DATA_W]) |=> lat_q[g]); // R5
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_ni)
      (clr_en && !set_en && int'(bank_idx) == g / DATA_W && mask[g % DATA_W]) |=> !lat_q[g]); // R6
    AST_UNMASKED_KEEPS: assert property (@(posedge clk) disable iff (!rst_ni)
      (upd_en && !(int'(bank_idx) == g / DATA_W && mask[g % DATA_W])) |=> $stable(lat_q[g])); // R5
  end

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    !upd_en |=> $stable(lat_q)); // R7
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 54
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] lvl_q
);
  logic [WIDTH-1:0] meta_q;
  logic [1:0]       age_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      lvl_q  <= '0;
    end else begin
      meta_q <= pin_in;
      lvl_q  <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)             age_q <= 2'd0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  AST_LEVEL_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (lvl_q == $past(pin_in, 2))); // R8
endmodule

// File: rtl/gpio_func_regs.sv
module gpio_func_regs
  import gpio_func_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int FIELD_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]         pin_in,
  output logic [NUM_PINS-1:0]         pin_oe,
  output logic [NUM_PINS-1:0]         pin_out,
  output logic [NUM_PINS*FIELD_W-1:0] pin_func
);
  localparam int WORD_W     = ADDR_W - 2;
  localparam int PPR        = DATA_W / FIELD_W;
  localparam int PAD_W      = DATA_W - PPR * FIELD_W;
  localparam int NUM_FWORDS = (NUM_PINS + PPR - 1) / PPR;
  localparam int NUM_BANKS  = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int SET_WORD   = OFS_SET / 4;
  localparam int CLR_WORD   = OFS_CLR / 4;
  localparam int LVL_WORD   = OFS_LEVEL / 4;
  localparam int FUNC_WORD  = OFS_FUNC / 4;

  logic                        rst_ni;
  logic [WORD_W-1:0]           word_idx;
  logic                        func_hit, set_hit, clr_hit, lvl_hit;
  logic [WORD_W-1:0]           func_idx, set_idx, clr_idx, lvl_idx, bank_idx;
  logic [DATA_W-1:0]           func_rd;
  logic [NUM_PINS-1:0]         lvl_q;
  logic [NUM_BANKS*DATA_W-1:0] lvl_pad;

  gpio_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign func_hit = int'(word_idx) >= FUNC_WORD && int'(word_idx) < FUNC_WORD + NUM_FWORDS;
  assign set_hit  = int'(word_idx) >= SET_WORD  && int'(word_idx) < SET_WORD + NUM_BANKS;
  assign clr_hit  = int'(word_idx) >= CLR_WORD  && int'(word_idx) < CLR_WORD + NUM_BANKS;
  assign lvl_hit  = int'(word_idx) >= LVL_WORD  && int'(word_idx) < LVL_WORD + NUM_BANKS;
  assign func_idx = WORD_W'(int'(word_idx) - FUNC_WORD);
  assign set_idx  = WORD_W'(int'(word_idx) - SET_WORD);
  assign clr_idx  = WORD_W'(int'(word_idx) - CLR_WORD);
  assign lvl_idx  = WORD_W'(int'(word_idx) - LVL_WORD);
  assign bank_idx = set_hit ? set_idx : clr_idx;

  gpio_fsel_bank #(
    .NUM_PINS (NUM_PINS),
    .FIELD_W  (FIELD_W),
    .DATA_W   (DATA_W),
    .IDX_W    (WORD_W)
  ) u_fsel (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_en   (bus_wr && func_hit),
    .wr_idx  (func_idx),
    .wr_data (bus_wdata),
    .rd_idx  (func_idx),
    .rd_data (func_rd),
    .func_q  (pin_func)
  );

  gpio_out_latch #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .IDX_W    (WORD_W)
  ) u_latch (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .set_en   (bus_wr && set_hit),
    .clr_en   (bus_wr && clr_hit),
    .bank_idx (bank_idx),
    .mask     (bus_wdata),
    .lat_q    (pin_out)
  );

  gpio_in_sync #(
    .WIDTH (NUM_PINS)
  ) u_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .pin_in (pin_in),
    .lvl_q  (lvl_q)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_oe
    assign pin_oe[g] = (pin_func[g*FIELD_W +: FIELD_W] == FIELD_W'(FN_OUTPUT));

    AST_OE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
      (bus_wr && func_hit && int'(func_idx) == g / PPR) |=>
        (pin_oe[g] == ($past(bus_wdata[(g % PPR)*FIELD_W +: FIELD_W]) == FIELD_W'(FN_OUTPUT)))); // R4
  end

  always_comb begin
    lvl_pad = '0;
    lvl_pad[NUM_PINS-1:0] = lvl_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (func_hit)     bus_rdata = func_rd;
    else if (lvl_hit) bus_rdata = lvl_pad[int'(lvl_idx)*DATA_W +: DATA_W];
  end

  always_comb begin
    if (rst_ni && func_hit) begin
      AST_FSEL_PAD_ZERO: assert (bus_rdata[DATA_W-1 -: PAD_W] == '0); // R3
    end
    if (rst_ni && (set_hit || clr_hit)) begin
      AST_STROBE_READS_ZERO: assert (bus_rdata == '0); // R9
    end
  end
endmodule

// File: tb/gpio_func_regs_bench.sv
module gpio_func_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 54;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    bus_addr;
  logic          bus_wr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_oe;
  logic [NP-1:0] pin_out;
  logic [NP*3-1:0] pin_func;

  int n_tests = 0;
  int n_fail  = 0;

  logic [2:0]    exp_fn [NP];
  logic [NP-1:0] exp_lat;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_func_regs u_gpio_func_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .pin_func  (pin_func)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] fn_word(input int r);
    logic [31:0] w = '0;
    for (int s = 0; s < 10; s++)
      if (r*10 + s < NP) w[s*3 +: 3] = exp_fn[r*10 + s];
    return w;
  endfunction

  task automatic model_fn_write(input int r, input logic [31:0] d);
    for (int s = 0; s < 10; s++)
      if (r*10 + s < NP) exp_fn[r*10 + s] = d[s*3 +: 3];
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int r = 0; r < 6; r++) begin
      bus_read(8'(r*4), d);
      chk("R1 function word after reset", 64'(d), 64'(0));
    end
    chk("R1 pin_oe after reset", 64'(pin_oe), 64'(0));
    chk("R1 pin_out after reset", 64'(pin_out), 64'(0));
    bus_read(8'h34, d); chk("R1 level low word", 64'(d), 64'(0));
    bus_read(8'h38, d); chk("R1 level high word", 64'(d), 64'(0));
  endtask

  task automatic t_fsel_map;
    logic [31:0] d;
    logic [31:0] pat [6];
    pat[0] = 32'h3FFF_FFFF; pat[1] = 32'h1234_5678; pat[2] = 32'h2AAA_AAAA;
    pat[3] = 32'h0555_5555; pat[4] = 32'h3A5C_96E1; pat[5] = 32'hFFFF_FFFF;
    for (int r = 0; r < 6; r++) begin
      bus_write(8'(r*4), pat[r]);
      model_fn_write(r, pat[r]);
    end
    for (int r = 0; r < 6; r++) begin
      bus_read(8'(r*4), d);
      chk("R2 function word readback", 64'(d), 64'(fn_word(r)));
    end
    for (int p = 0; p < NP; p++)
      chk("R2 pin_func field", 64'(pin_func[p*3 +: 3]), 64'(exp_fn[p]));
    bus_write(8'h00, 32'hFFFF_FFFF);
    model_fn_write(0, 32'hFFFF_FFFF);
    bus_read(8'h00, d); chk("R3 top bits of word 0x00", 64'(d), 64'h3FFF_FFFF);
    bus_read(8'h14, d); chk("R3 nonexistent pins in word 0x14", 64'(d), 64'h0000_0FFF);
    for (int r = 0; r < 6; r++) begin
      bus_write(8'(r*4), 32'h0);
      model_fn_write(r, 32'h0);
    end
  endtask

  task automatic t_oe_codes;
    for (int c = 0; c < 8; c++) begin
      bus_write(8'h00, 32'(c) << 21);
      chk("R4 pin 7 code export", 64'(pin_func[21 +: 3]), 64'(c));
      chk("R4 output enable per code", 64'(pin_oe), (c == 1) ? 64'h80 : 64'h0);
    end
    bus_write(8'h14, 32'h0000_0249);
    chk("R4 pins 50-53 driving", 64'(pin_oe), 64'h003C_0000_0000_0000);
    bus_write(8'h00, 32'h0);
    bus_write(8'h14, 32'h0);
  endtask

  task automatic t_set_clear;
    bus_write(8'h1C, 32'h0000_00A5);
    exp_lat[31:0] = exp_lat[31:0] | 32'h0000_00A5;
    chk("R5 set low bank", 64'(pin_out), 64'(exp_lat));
    bus_write(8'h1C, 32'h8000_0002);
    exp_lat[31:0] = exp_lat[31:0] | 32'h8000_0002;
    chk("R5 set keeps zero-mask pins", 64'(pin_out), 64'(exp_lat));
    bus_write(8'h20, 32'hFFFF_FFFF);
    exp_lat[53:32] = '1;
    chk("R5 set high bank", 64'(pin_out), 64'(exp_lat));
    bus_write(8'h28, 32'h0000_0021);
    exp_lat[31:0] = exp_lat[31:0] & ~32'h0000_0021;
    chk("R6 clear low bank", 64'(pin_out), 64'(exp_lat));
    bus_write(8'h2C, 32'h0020_0001);
    exp_lat[32] = 1'b0; exp_lat[53] = 1'b0;
    chk("R6 clear high bank pins 32 and 53", 64'(pin_out), 64'(exp_lat));
    bus_write(8'h28, 32'hFFFF_FFFF);
    bus_write(8'h2C, 32'hFFFF_FFFF);
    exp_lat = '0;
    chk("R6 clear all", 64'(pin_out), 64'(0));
  endtask

  task automatic t_retain;
    bus_write(8'h20, 32'h0000_0100);
    exp_lat[40] = 1'b1;
    chk("R7 latch set while input, no drive", 64'(pin_oe[40]), 64'(0));
    chk("R7 latch value while input", 64'(pin_out[40]), 64'(1));
    bus_write(8'h10, 32'h0000_0001);
    chk("R7 drive enabled after switch", 64'(pin_oe[40]), 64'(1));
    chk("R7 stored level driven", 64'(pin_out), 64'(exp_lat));
    bus_write(8'h10, 32'h0000_0004);
    chk("R7 latch kept under alternate", 64'(pin_out[40]), 64'(1));
    bus_write(8'h10, 32'h0);
    bus_write(8'h2C, 32'h0000_0100);
    exp_lat[40] = 1'b0;
  endtask

  task automatic t_level;
    logic [31:0]   d;
    logic [NP-1:0] pat;
    pat = 54'h3F_0F0F_A5A5_C3C3;
    @(negedge clk);
    pin_in = pat;
    @(negedge clk);
    bus_read(8'h34, d); chk("R8 level not yet after one edge", 64'(d), 64'(0));
    @(negedge clk);
    bus_read(8'h34, d); chk("R8 level low word after two edges", 64'(d), 64'(pat[31:0]));
    bus_read(8'h38, d); chk("R8 level high word zero padded", 64'(d), 64'(pat[53:32]));
    @(negedge clk);
    pin_in = ~pat;
    @(negedge clk);
    @(negedge clk);
    bus_read(8'h38, d); chk("R8 level high word second pattern", 64'({10'b0, ~pat[53:32]}), 64'(d));
  endtask

  task automatic t_ignored;
    logic [31:0]   d;
    logic [NP-1:0] cur;
    cur = pin_in;
    bus_write(8'h34, 32'h0000_0000);
    bus_write(8'h38, 32'hFFFF_FFFF);
    bus_read(8'h34, d); chk("R9 level write ignored low", 64'(d), 64'(cur[31:0]));
    bus_read(8'h38, d); chk("R9 level write ignored high", 64'(d), 64'(cur[53:32]));
    chk("R9 latches untouched by level write", 64'(pin_out), 64'(exp_lat));
    bus_read(8'h00, d); chk("R9 fields untouched by level write", 64'(d), 64'(fn_word(0)));
    bus_write(8'h1C, 32'h0000_0003);
    exp_lat[1:0] = 2'b11;
    bus_read(8'h1C, d); chk("R9 set word reads zero", 64'(d), 64'(0));
    bus_read(8'h20, d); chk("R9 high set word reads zero", 64'(d), 64'(0));
    bus_read(8'h28, d); chk("R9 clear word reads zero", 64'(d), 64'(0));
    bus_read(8'h2C, d); chk("R9 high clear word reads zero", 64'(d), 64'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pin_in = '0;
    for (int p = 0; p < NP; p++) exp_fn[p] = 3'd0;
    exp_lat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_fsel_map;
    t_oe_codes;
    t_set_clear;
    t_retain;
    t_level;
    t_ignored;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule